// File: doc/BRIEF.md
# Escaped Byte-Stream Command and Memory-Write Decoder

This block accepts a byte stream from a parallel USB FIFO and splits it into two kinds of traffic. The first kind is in-band control commands. Each command is introduced by an escape byte and drives a set of control levels plus a one-cycle reset pulse. The second kind is plain data. Data bytes are paired into 16-bit words and parsed as memory-write packets.

A packet names a target channel, a first address and a last address, followed by the data words. The block drives a memory write port with a DAC index, an address, the data and a write enable. It raises the enable only when the channel's board field matches the board-address input and the DAC index exists.

A command may arrive between any two bytes without disturbing the packet in progress. A reset command returns the parser to the head of a packet, which recovers from a stream that has lost alignment.

Top module: `esc_stream_decoder`

## Requirements
- R1: The escape byte is 0xA5. The byte that follows an escape is a command, except that a second 0xA5 stands for one literal 0xA5 data byte.
- R2: The command code is the byte with bit 0 cleared, and bit 0 = 0 means set, bit 0 = 1 means clear. Code 0x02 controls the soft trigger, 0x04 arm (`armEn`), 0x06 clock doubling (`clkDoubleEn`) and 0x08 frame start (`startEn`). Any other code, and 0x01, leaves every output unchanged.
- R3: Data bytes pair into 16-bit words, with the first byte received as bits 7:0 and the second as bits 15:8.
- R4: A packet is four or more words in this order: channel, first address, last address, then data. Each data word is written to an address starting at the first address and rising by one per word, until the word written at the last address ends the packet. `memWe` is high for one cycle, in the cycle after the edge that accepts the second byte of the data word.
- R5: A write is performed only when channel bits 15:4 equal `boardId` and bits 3:0 (driven on `memChan`) are below NUM_DACS (3). Otherwise the packet is still parsed, but `memWe` stays low.
- R6: The address wraps from 0xFFFF to 0x0000, and no length check is made. A last address below the first address writes through the wrap.
- R7: A command received between the two bytes of a word, or between the words of a packet, takes effect and leaves the word and the packet intact.
- R8: Command 0x00 pulses `ctlReset` for exactly one cycle. It returns the parser to the channel word, discards a half-received word and clears the soft trigger, `armEn`, `clkDoubleEn` and `startEn`.
- R9: `trigOut` is the OR of the soft trigger level and `extTrig`.
- R10: After reset, `ctlReset`, `trigOut` (with `extTrig` low), `armEn`, `clkDoubleEn`, `startEn` and `memWe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byteData | input | 8 | Stream byte |
| byteValid | input | 1 | Byte present |
| byteReady | output | 1 | Byte accepted when high with byteValid |
| boardId | input | 4 | This board's address |
| extTrig | input | 1 | External trigger input |
| trigOut | output | 1 | Combined trigger |
| ctlReset | output | 1 | One-cycle reset pulse from the stream |
| armEn | output | 1 | Arm level |
| clkDoubleEn | output | 1 | Clock doubling select level |
| startEn | output | 1 | Frame start enable level |
| memWe | output | 1 | Memory write strobe |
| memChan | output | 4 | DAC index of the write |
| memAddr | output | 16 | Write address |
| memData | output | 16 | Write data |

## Verification
The assertions check, on every cycle, the properties that hold at all times:
- the reset pulse lasts a single cycle and leaves every control level clear;
- each write strobe follows an accepted byte and lasts one cycle;
- the upper data byte of a write equals the byte just taken;
- control levels move only after an accepted byte;
- the external trigger always reaches the trigger output.

The bench scenarios are needed for the behaviours that depend on a sequence of bytes: escape literals, address sequencing and wrap, board and DAC filtering, commands placed inside words, and resynchronisation after a truncated packet.

// File: rtl/esc_dec_pkg.sv
package esc_dec_pkg;
  localparam logic [7:0] ESC_BYTE = 8'hA5;

  typedef enum logic [6:0] {
    CMD_RESET = 7'd0,
    CMD_TRIG  = 7'd1,
    CMD_ARM   = 7'd2,
    CMD_DBL   = 7'd3,
    CMD_START = 7'd4
  } cmd_code_t;

  typedef enum logic [1:0] {
    PK_CHAN  = 2'd0,
    PK_FIRST = 2'd1,
    PK_LAST  = 2'd2,
    PK_DATA  = 2'd3
  } pkt_state_t;

  typedef struct packed {
    logic byteLo;
    logic latchChan;
    logic latchFirst;
    logic latchLast;
    logic writeWord;
    logic clearAll;
  } dp_strobe_t;
endpackage

// File: rtl/esc_dec_ctrl.sv
module esc_dec_ctrl
  import esc_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] byteData,
  input  logic       byteFire,
  input  logic       lastWord,
  output dp_strobe_t strobe,
  output logic       ctlReset,
  output logic       softTrig,
  output logic       armEn,
  output logic       clkDoubleEn,
  output logic       startEn
);
  logic       escPending;
  logic       haveLow;
  pkt_state_t state;
  logic       isEsc, isCmd, isData, wordDone, doReset, cmdSet;
  logic [6:0] cmdCode;

  always_comb begin
    isEsc    = byteFire && !escPending && (byteData == ESC_BYTE);
    isCmd    = byteFire && escPending && (byteData != ESC_BYTE);
    isData   = byteFire && (escPending ? (byteData == ESC_BYTE) : (byteData != ESC_BYTE));
    cmdCode  = byteData[7:1];
    cmdSet   = ~byteData[0];
    doReset  = isCmd && (cmdCode == CMD_RESET) && cmdSet;
    wordDone = isData && haveLow;
    strobe.byteLo     = isData && !haveLow;
    strobe.latchChan  = wordDone && (state == PK_CHAN);
    strobe.latchFirst = wordDone && (state == PK_FIRST);
    strobe.latchLast  = wordDone && (state == PK_LAST);
    strobe.writeWord  = wordDone && (state == PK_DATA);
    strobe.clearAll   = doReset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      escPending  <= 1'b0;
      haveLow     <= 1'b0;
      state       <= PK_CHAN;
      ctlReset    <= 1'b0;
      softTrig    <= 1'b0;
      armEn       <= 1'b0;
      clkDoubleEn <= 1'b0;
      startEn     <= 1'b0;
    end else begin
      ctlReset <= doReset;
      if (isEsc) escPending <= 1'b1;
      else if (byteFire) escPending <= 1'b0;

      if (doReset) begin
        haveLow     <= 1'b0;
        state       <= PK_CHAN;
        softTrig    <= 1'b0;
        armEn       <= 1'b0;
        clkDoubleEn <= 1'b0;
        startEn     <= 1'b0;
      end else begin
        if (isData) haveLow <= !haveLow;
        if (wordDone) begin
          unique case (state)
            PK_CHAN:  state <= PK_FIRST;
            PK_FIRST: state <= PK_LAST;
            PK_LAST:  state <= PK_DATA;
            PK_DATA:  if (lastWord) state <= PK_CHAN;
          endcase
        end
        if (isCmd) begin
          unique case (cmdCode)
            CMD_TRIG:  softTrig    <= cmdSet;
            CMD_ARM:   armEn       <= cmdSet;
            CMD_DBL:   clkDoubleEn <= cmdSet;
            CMD_START: startEn     <= cmdSet;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/esc_dec_dpath.sv
module esc_dec_dpath
  import esc_dec_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int DAC_W    = 4,
  parameter int BOARD_W  = 4,
  parameter int NUM_DACS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         byteData,
  input  logic [BOARD_W-1:0] boardId,
  input  dp_strobe_t         strobe,
  output logic               lastWord,
  output logic               memWe,
  output logic [DAC_W-1:0]   memChan,
  output logic [WORD_W-1:0]  memAddr,
  output logic [WORD_W-1:0]  memData
);
  localparam int HI_W = WORD_W - DAC_W;

  logic [7:0]        lowByte;
  logic [WORD_W-1:0] wordVal, curAddr, lastAddr;
  logic [DAC_W-1:0]  chanIdx;
  logic              chanOk, chanMatch;

  always_comb begin
    wordVal   = {byteData, lowByte};
    chanMatch = (wordVal[WORD_W-1:DAC_W] == HI_W'(boardId)) &&
                ({{(32-DAC_W){1'b0}}, wordVal[DAC_W-1:0]} < NUM_DACS);
    lastWord  = (curAddr == lastAddr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowByte  <= '0;
      curAddr  <= '0;
      lastAddr <= '0;
      chanIdx  <= '0;
      chanOk   <= 1'b0;
      memWe    <= 1'b0;
      memChan  <= '0;
      memAddr  <= '0;
      memData  <= '0;
    end else begin
      memWe <= 1'b0;
      if (strobe.clearAll) chanOk <= 1'b0;
      if (strobe.byteLo) lowByte <= byteData;
      if (strobe.latchChan) begin
        chanIdx <= wordVal[DAC_W-1:0];
        chanOk  <= chanMatch;
      end
      if (strobe.latchFirst) curAddr <= wordVal;
      if (strobe.latchLast) lastAddr <= wordVal;
      if (strobe.writeWord) begin
        memWe   <= chanOk;
        memChan <= chanIdx;
        memAddr <= curAddr;
        memData <= wordVal;
        curAddr <= curAddr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/esc_stream_decoder.sv
module esc_stream_decoder
  import esc_dec_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int DAC_W    = 4,
  parameter int BOARD_W  = 4,
  parameter int NUM_DACS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         byteData,
  input  logic               byteValid,
  output logic               byteReady,
  input  logic [BOARD_W-1:0] boardId,
  input  logic               extTrig,
  output logic               trigOut,
  output logic               ctlReset,
  output logic               armEn,
  output logic               clkDoubleEn,
  output logic               startEn,
  output logic               memWe,
  output logic [DAC_W-1:0]   memChan,
  output logic [WORD_W-1:0]  memAddr,
  output logic [WORD_W-1:0]  memData
);
  dp_strobe_t strobe;
  logic       lastWord, softTrig, byteFire;

  assign byteReady = 1'b1;
  assign byteFire  = byteValid && byteReady;
  assign trigOut   = softTrig || extTrig;

  esc_dec_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .byteData(byteData), .byteFire(byteFire),
    .lastWord(lastWord), .strobe(strobe), .ctlReset(ctlReset),
    .softTrig(softTrig), .armEn(armEn), .clkDoubleEn(clkDoubleEn),
    .startEn(startEn)
  );

  esc_dec_dpath #(
    .WORD_W(WORD_W), .DAC_W(DAC_W), .BOARD_W(BOARD_W), .NUM_DACS(NUM_DACS)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .byteData(byteData), .boardId(boardId),
    .strobe(strobe), .lastWord(lastWord), .memWe(memWe), .memChan(memChan),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/esc_dec_checker.sv
module esc_dec_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        byteData,
  input logic              byteValid,
  input logic              byteReady,
  input logic              extTrig,
  input logic              trigOut,
  input logic              ctlReset,
  input logic              armEn,
  input logic              clkDoubleEn,
  input logic              startEn,
  input logic              memWe,
  input logic [WORD_W-1:0] memData
);
  // R8
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctlReset |=> !ctlReset);
  // R8
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctlReset |-> (!armEn && !clkDoubleEn && !startEn));
  // R4
  write_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> $past(byteValid && byteReady));
  // R4
  write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |=> !memWe);
  // R3
  write_high_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> (memData[15:8] == $past(byteData)));
  // R9
  ext_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    extTrig |-> trigOut);
  // R2
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byteValid) |-> ($stable(armEn) && $stable(startEn) && $stable(clkDoubleEn)));
endmodule

bind esc_stream_decoder esc_dec_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byteData(byteData), .byteValid(byteValid),
  .byteReady(byteReady), .extTrig(extTrig), .trigOut(trigOut),
  .ctlReset(ctlReset), .armEn(armEn), .clkDoubleEn(clkDoubleEn),
  .startEn(startEn), .memWe(memWe), .memData(memData)
);

// File: tb/sim_esc_stream_decoder.sv
`timescale 1ns/1ps
module sim_esc_stream_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  byteData = '0;
  logic        byteValid = 1'b0;
  logic        byteReady;
  logic [3:0]  boardId = 4'd2;
  logic        extTrig = 1'b0;
  logic        trigOut, ctlReset, armEn, clkDoubleEn, startEn, memWe;
  logic [3:0]  memChan;
  logic [15:0] memAddr, memData;

  int checks = 0;
  int failures = 0;
  int wrCount = 0;
  int rstPulses = 0;
  logic [3:0]  wrChan [64];
  logic [15:0] wrAddr [64];
  logic [15:0] wrData [64];

  always #4 clk = ~clk;

  esc_stream_decoder u0 (
    .clk(clk), .rst_n(rst_n), .byteData(byteData), .byteValid(byteValid),
    .byteReady(byteReady), .boardId(boardId), .extTrig(extTrig),
    .trigOut(trigOut), .ctlReset(ctlReset), .armEn(armEn),
    .clkDoubleEn(clkDoubleEn), .startEn(startEn), .memWe(memWe),
    .memChan(memChan), .memAddr(memAddr), .memData(memData)
  );

  always @(negedge clk) begin
    if (rst_n && memWe && wrCount < 64) begin
      wrChan[wrCount] = memChan;
      wrAddr[wrCount] = memAddr;
      wrData[wrCount] = memData;
      wrCount++;
    end
    if (rst_n && ctlReset) rstPulses++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    byteData  = b;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic sendDataByte(input logic [7:0] b);
    if (b == 8'hA5) sendByte(8'hA5);
    sendByte(b);
  endtask

  task automatic sendWord(input logic [15:0] w);
    sendDataByte(w[7:0]);
    sendDataByte(w[15:8]);
  endtask

  task automatic sendCmd(input logic [7:0] c);
    sendByte(8'hA5);
    sendByte(c);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic checkWrite(input int idx, input logic [3:0] ch, input logic [15:0] a,
                            input logic [15:0] d, input string req);
    check(wrChan[idx] == ch, req, wrChan[idx], ch);
    check(wrAddr[idx] == a, req, wrAddr[idx], a);
    check(wrData[idx] == d, req, wrData[idx], d);
  endtask

  task automatic t_reset();
    check({ctlReset, trigOut, armEn, clkDoubleEn, startEn, memWe} == 6'b0, "R10",
          {ctlReset, trigOut, armEn, clkDoubleEn, startEn, memWe}, 0);
  endtask

  task automatic t_cmds();
    sendCmd(8'h04); check(armEn == 1'b1, "R2 arm set", armEn, 1);
    sendCmd(8'h06); check(clkDoubleEn == 1'b1, "R2 dbl set", clkDoubleEn, 1);
    sendCmd(8'h08); check(startEn == 1'b1, "R2 start set", startEn, 1);
    sendCmd(8'h02); check(trigOut == 1'b1, "R2 trig set", trigOut, 1);
    sendCmd(8'h05); check(armEn == 1'b0, "R2 arm clear", armEn, 0);
    sendCmd(8'h03); check(trigOut == 1'b0, "R2 trig clear", trigOut, 0);
    sendCmd(8'h0A); sendCmd(8'h01); settle();
    check({armEn, clkDoubleEn, startEn, trigOut, ctlReset} == 5'b01100, "R2 unknown code",
          {armEn, clkDoubleEn, startEn, trigOut, ctlReset}, 5'b01100);
    check(rstPulses == 0, "R2 0x01 no reset", rstPulses, 0);
  endtask

  task automatic t_trig();
    extTrig = 1'b1; #1;
    check(trigOut == 1'b1, "R9 ext", trigOut, 1);
    extTrig = 1'b0; #1;
    check(trigOut == 1'b0, "R9 none", trigOut, 0);
  endtask

  task automatic t_basic();
    int base = wrCount;
    sendWord(16'h0021); sendWord(16'h0010); sendWord(16'h0012);
    sendWord(16'h1234); sendWord(16'hBEEF); sendWord(16'h0F0E);
    settle();
    check(wrCount - base == 3, "R4 count", wrCount - base, 3);
    checkWrite(base, 4'd1, 16'h0010, 16'h1234, "R3 R4");
    checkWrite(base + 1, 4'd1, 16'h0011, 16'hBEEF, "R4");
    checkWrite(base + 2, 4'd1, 16'h0012, 16'h0F0E, "R4");
  endtask

  task automatic t_literal();
    int base = wrCount;
    sendWord(16'h0020); sendWord(16'h00A5); sendWord(16'h00A5); sendWord(16'hA5A5);
    settle();
    check(wrCount - base == 1, "R1 count", wrCount - base, 1);
    checkWrite(base, 4'd0, 16'h00A5, 16'hA5A5, "R1");
    check(rstPulses == 0, "R1 no cmd", rstPulses, 0);
  endtask

  task automatic t_filter();
    int base = wrCount;
    sendWord(16'h0031); sendWord(16'h0000); sendWord(16'h0001);
    sendWord(16'h1111); sendWord(16'h2222);
    sendWord(16'h0023); sendWord(16'h0005); sendWord(16'h0005); sendWord(16'h3333);
    sendWord(16'h0022); sendWord(16'h0007); sendWord(16'h0007); sendWord(16'h4444);
    settle();
    check(wrCount - base == 1, "R5 filtered", wrCount - base, 1);
    checkWrite(base, 4'd2, 16'h0007, 16'h4444, "R5 sync kept");
  endtask

  task automatic t_wrap();
    int base = wrCount;
    sendWord(16'h0020); sendWord(16'hFFFF); sendWord(16'h0001);
    sendWord(16'hAAAA); sendWord(16'hBBBB); sendWord(16'hCCCC);
    settle();
    check(wrCount - base == 3, "R6 count", wrCount - base, 3);
    checkWrite(base, 4'd0, 16'hFFFF, 16'hAAAA, "R6");
    checkWrite(base + 1, 4'd0, 16'h0000, 16'hBBBB, "R6");
    checkWrite(base + 2, 4'd0, 16'h0001, 16'hCCCC, "R6");
  endtask

  task automatic t_midcmd();
    int base = wrCount;
    sendWord(16'h0021);
    sendCmd(8'h04);
    sendWord(16'h0040); sendWord(16'h0041);
    sendByte(8'h34); sendCmd(8'h09); sendByte(8'h12);
    sendWord(16'h5678);
    settle();
    check(armEn == 1'b1, "R7 arm", armEn, 1);
    check(wrCount - base == 2, "R7 count", wrCount - base, 2);
    checkWrite(base, 4'd1, 16'h0040, 16'h1234, "R7");
    checkWrite(base + 1, 4'd1, 16'h0041, 16'h5678, "R7");
  endtask

  task automatic t_resync();
    int base = wrCount;
    int p0 = rstPulses;
    sendCmd(8'h08);
    sendWord(16'h0021); sendWord(16'h0050); sendByte(8'h77);
    sendCmd(8'h00);
    settle();
    check(rstPulses - p0 == 1, "R8 pulse", rstPulses - p0, 1);
    check({armEn, startEn, clkDoubleEn} == 3'b0, "R8 levels", {armEn, startEn, clkDoubleEn}, 0);
    sendWord(16'h0022); sendWord(16'h0060); sendWord(16'h0060); sendWord(16'h9999);
    settle();
    check(wrCount - base == 1, "R8 count", wrCount - base, 1);
    checkWrite(base, 4'd2, 16'h0060, 16'h9999, "R8 resync");
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmds();
    t_trig();
    t_basic();
    t_literal();
    t_filter();
    t_wrap();
    t_midcmd();
    t_resync();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule